// File: doc/BRIEF.md
# Banked Vector Memory Access Unit

This unit runs one vector load or store at a time against sixteen word-interleaved memory banks. A start pulse latches a base address, a stride, a vector of per-element offsets, the addressing mode and the element count. The unit then walks the elements in order and issues at most one bank request per cycle. Each element address is found in one of three ways: from consecutive words, from a constant stride, or by adding a per-element offset to the base (gather for loads, scatter for stores).

Every bank stays busy for a fixed number of cycles after it accepts an access. An element whose bank is still busy holds issue in place, and the unit counts each such cycle. Strides that share factors with the bank count therefore show up as a nonzero stall count. A load returns its word after a fixed latency, tagged with its element index, on a register-file write port. A store takes its data from a register-file read port addressed by the issuing element.

Top module: `vbm_top`

## Requirements
- R1: In unit mode (mode_i = 2'b00), element i uses word address base + i, modulo 256. Word address a maps to bank a[3:0] and row a[7:4]. Sixteen consecutive elements therefore request sixteen different banks and cause no stall cycles.
- R2: After a bank accepts a request, it accepts none in the next 3 cycles. The earliest next request is the 4th cycle after the accepting one, so a stride of 16 costs 3 stall cycles for every element after the first.
- R3: In strided mode (mode_i = 2'b01), element i uses word address base + i × stride, modulo 256. An odd stride causes no stall cycles.
- R4: In indexed mode (mode_i[1] = 1), element i uses word address base + V[i], modulo 256. V[i] is idx_vec_i[8i+7:8i], and it is latched at start.
- R5: At most one bit of bank_req_o is high in any cycle. Elements are requested in ascending index order, starting the cycle after start. Issue holds on an element for as long as its target bank is busy.
- R6: stall_cnt_o is zero after reset. It clears on an accepted start and rises by one on each cycle in which the pending element is blocked by a busy bank.
- R7: For a load, wb_valid_o is high exactly 12 cycles after the cycle in which the element's bank request is high. In that cycle wb_elem_o holds the element index and wb_data_o holds the addressed word. Writebacks arrive in element order.
- R8: The element count is vlen_i clamped to 64. A vlen_i of 0 issues no request and raises done_o in the cycle after start.
- R9: done_o is a one-cycle pulse. For a load it comes in the cycle after the last writeback. For a store it comes in the cycle after the last request.
- R10: For a store (store_i = 1), st_elem_o holds the issuing element's index in its request cycle, and st_data_i is written to the addressed word. A store produces no writeback.
- R11: A start pulse while an operation is in progress is ignored, and the running operation completes with its own parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| store_i | input | 1 | 1 = store, 0 = load |
| mode_i | input | 2 | 00 unit, 01 strided, 1x indexed |
| base_i | input | 8 | Base word address |
| stride_i | input | 8 | Word stride for strided mode |
| vlen_i | input | 7 | Requested element count |
| idx_vec_i | input | 512 | Per-element offsets, 8 bits each |
| st_elem_o | output | 6 | Element index for the store-data read port |
| st_data_i | input | 64 | Store data for st_elem_o |
| bank_req_o | output | 16 | Per-bank request strobes |
| wb_valid_o | output | 1 | Load writeback valid |
| wb_elem_o | output | 6 | Writeback element index |
| wb_data_o | output | 64 | Writeback data |
| done_o | output | 1 | Operation complete pulse |
| stall_cnt_o | output | 16 | Bank-conflict stall cycles of the current or last operation |

## Verification
On every cycle, the embedded properties check several rules. A bank never receives a request while busy, and its requests are at least four cycles apart. Requests are never more than one-hot. Writebacks carry the next expected element index. Stores never write back, done is a single pulse, and a start during an operation leaves the latched parameters alone. The other behaviours can be shown only by the bench's scenarios, with a behavioural model compared every cycle. These are the exact stall totals for conflicting strides and offsets, the returned data matching what earlier scatters wrote, the 12-cycle return timing, the clamp of the element count, and the zero-length case.

// File: rtl/vbm_pkg.sv
package vbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ISSUE = 2'd1,
    PH_DRAIN = 2'd2
  } phase_e;
endpackage

// File: rtl/vbm_agu.sv
module vbm_agu #(
  parameter int ADDR_W = 8,
  parameter int MAX_VL = 64,
  parameter int ELEM_W = 6
) (
  input  logic [1:0]               mode_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [ADDR_W-1:0]        stride_i,
  input  logic [MAX_VL*ADDR_W-1:0] idx_vec_i,
  input  logic [ELEM_W-1:0]        elem_i,
  output logic [ADDR_W-1:0]        addr_o
);
  logic [ADDR_W-1:0] elem_ext;
  logic [ADDR_W-1:0] offset;

  assign elem_ext = ADDR_W'(elem_i);

  always_comb begin
    if (mode_i[1])      offset = idx_vec_i[elem_i*ADDR_W +: ADDR_W];
    else if (mode_i[0]) offset = stride_i * elem_ext;
    else                offset = elem_ext;
  end

  assign addr_o = base_i + offset;
endmodule

// File: rtl/vbm_bank.sv
module vbm_bank #(
  parameter int ROW_W    = 4,
  parameter int WORD_W   = 64,
  parameter int ELEM_W   = 6,
  parameter int BUSY_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [ELEM_W-1:0] tag_i,
  output logic              busy_o,
  output logic              rd_vld_o,
  output logic [ELEM_W-1:0] rd_tag_o,
  output logic [WORD_W-1:0] rd_data_o
);
  localparam int ROWS = 1 << ROW_W;
  localparam int BC_W = $clog2(BUSY_CYC + 1);

  logic [BC_W-1:0]   busy_q;
  logic              rd_vld_q;
  logic [ELEM_W-1:0] rd_tag_q;
  logic [WORD_W-1:0] rd_data_q;
  logic [WORD_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= '0;
      rd_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= req_i && !we_i;
      if (req_i)              busy_q <= BC_W'(BUSY_CYC - 1);
      else if (busy_q != '0)  busy_q <= busy_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (req_i && we_i) mem_q[row_i] <= wdata_i;
    if (req_i && !we_i) begin
      rd_data_q <= mem_q[row_i];
      rd_tag_q  <= tag_i;
    end
  end

  assign busy_o    = busy_q != '0;
  assign rd_vld_o  = rd_vld_q;
  assign rd_tag_o  = rd_tag_q;
  assign rd_data_o = rd_data_q;

  a_r2_no_accept_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |-> !busy_o);

  if (BUSY_CYC > 1) begin : g_gap_chk
    a_r2_req_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |=> !req_i);
  end
endmodule

// File: rtl/vbm_ret_pipe.sv
module vbm_ret_pipe #(
  parameter int DEPTH  = 11,
  parameter int ELEM_W = 6,
  parameter int WORD_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [ELEM_W-1:0] tag_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              vld_o,
  output logic [ELEM_W-1:0] tag_o,
  output logic [WORD_W-1:0] data_o
);
  if (DEPTH == 0) begin : g_bypass
    assign vld_o  = vld_i;
    assign tag_o  = tag_i;
    assign data_o = data_i;
  end else begin : g_pipe
    logic [DEPTH-1:0]  vld_q;
    logic [ELEM_W-1:0] tag_q [DEPTH];
    logic [WORD_W-1:0] dat_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else begin
        vld_q[0] <= vld_i;
        for (int s = 1; s < DEPTH; s++) vld_q[s] <= vld_q[s-1];
      end
    end

    always_ff @(posedge clk_i) begin
      tag_q[0] <= tag_i;
      dat_q[0] <= data_i;
      for (int s = 1; s < DEPTH; s++) begin
        tag_q[s] <= tag_q[s-1];
        dat_q[s] <= dat_q[s-1];
      end
    end

    assign vld_o  = vld_q[DEPTH-1];
    assign tag_o  = tag_q[DEPTH-1];
    assign data_o = dat_q[DEPTH-1];
  end
endmodule

// File: rtl/vbm_issue_ctrl.sv
module vbm_issue_ctrl
  import vbm_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int N_BANKS = 16,
  parameter int BANK_W  = 4,
  parameter int MAX_VL  = 64,
  parameter int ELEM_W  = 6,
  parameter int CNT_W   = 7,
  parameter int STALL_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     store_i,
  input  logic [1:0]               mode_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [ADDR_W-1:0]        stride_i,
  input  logic [CNT_W-1:0]         vlen_i,
  input  logic [MAX_VL*ADDR_W-1:0] idx_vec_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [N_BANKS-1:0]       bank_busy_i,
  input  logic                     wb_valid_i,
  output logic [1:0]               mode_o,
  output logic [ADDR_W-1:0]        base_o,
  output logic [ADDR_W-1:0]        stride_o,
  output logic [MAX_VL*ADDR_W-1:0] idx_vec_o,
  output logic [ELEM_W-1:0]        elem_o,
  output logic                     fire_o,
  output logic                     store_o,
  output logic                     done_o,
  output logic [STALL_W-1:0]       stall_cnt_o,
  output logic [CNT_W-1:0]         ret_cnt_o
);
  phase_e                   phase_q;
  logic                     store_q, done_q;
  logic [1:0]               mode_q;
  logic [ADDR_W-1:0]        base_q, stride_q;
  logic [MAX_VL*ADDR_W-1:0] idx_q;
  logic [CNT_W-1:0]         vl_q, issue_cnt_q, ret_cnt_q, vl_eff;
  logic [STALL_W-1:0]       stall_q;
  logic                     tgt_busy, fire, last_issue;

  assign vl_eff     = (vlen_i > CNT_W'(MAX_VL)) ? CNT_W'(MAX_VL) : vlen_i;
  assign tgt_busy   = bank_busy_i[addr_i[BANK_W-1:0]];
  assign fire       = (phase_q == PH_ISSUE) && !tgt_busy;
  assign last_issue = issue_cnt_q == vl_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q     <= PH_IDLE;
      store_q     <= 1'b0;
      done_q      <= 1'b0;
      mode_q      <= '0;
      base_q      <= '0;
      stride_q    <= '0;
      idx_q       <= '0;
      vl_q        <= '0;
      issue_cnt_q <= '0;
      ret_cnt_q   <= '0;
      stall_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (wb_valid_i) ret_cnt_q <= ret_cnt_q + 1'b1;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          store_q     <= store_i;
          mode_q      <= mode_i;
          base_q      <= base_i;
          stride_q    <= stride_i;
          idx_q       <= idx_vec_i;
          vl_q        <= vl_eff;
          issue_cnt_q <= '0;
          ret_cnt_q   <= '0;
          stall_q     <= '0;
          if (vl_eff == '0) done_q  <= 1'b1;
          else              phase_q <= PH_ISSUE;
        end
        PH_ISSUE: begin
          if (fire) begin
            issue_cnt_q <= issue_cnt_q + 1'b1;
            if (last_issue) begin
              if (store_q) begin
                done_q  <= 1'b1;
                phase_q <= PH_IDLE;
              end else begin
                phase_q <= PH_DRAIN;
              end
            end
          end else begin
            stall_q <= stall_q + 1'b1;
          end
        end
        PH_DRAIN: if (wb_valid_i && ret_cnt_q == vl_q - 1'b1) begin
          done_q  <= 1'b1;
          phase_q <= PH_IDLE;
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign mode_o      = mode_q;
  assign base_o      = base_q;
  assign stride_o    = stride_q;
  assign idx_vec_o   = idx_q;
  assign elem_o      = issue_cnt_q[ELEM_W-1:0];
  assign fire_o      = fire;
  assign store_o     = store_q;
  assign done_o      = done_q;
  assign stall_cnt_o = stall_q;
  assign ret_cnt_o   = ret_cnt_q;

  a_r8_issue_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ISSUE) |-> (issue_cnt_q < vl_q && vl_q <= CNT_W'(MAX_VL)));

  a_r11_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q != PH_IDLE && start_i) |=> ($stable(base_q) && $stable(vl_q) && $stable(mode_q)));
endmodule

// File: rtl/vbm_top.sv
module vbm_top #(
  parameter int N_BANKS  = 16,
  parameter int ADDR_W   = 8,
  parameter int WORD_W   = 64,
  parameter int MAX_VL   = 64,
  parameter int BUSY_CYC = 4,
  parameter int RD_LAT   = 12,
  parameter int STALL_W  = 16,
  parameter int BANK_W   = $clog2(N_BANKS),
  parameter int ELEM_W   = $clog2(MAX_VL),
  parameter int CNT_W    = $clog2(MAX_VL + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic                     store_i,
  input  logic [1:0]               mode_i,
  input  logic [ADDR_W-1:0]        base_i,
  input  logic [ADDR_W-1:0]        stride_i,
  input  logic [CNT_W-1:0]         vlen_i,
  input  logic [MAX_VL*ADDR_W-1:0] idx_vec_i,
  output logic [ELEM_W-1:0]        st_elem_o,
  input  logic [WORD_W-1:0]        st_data_i,
  output logic [N_BANKS-1:0]       bank_req_o,
  output logic                     wb_valid_o,
  output logic [ELEM_W-1:0]        wb_elem_o,
  output logic [WORD_W-1:0]        wb_data_o,
  output logic                     done_o,
  output logic [STALL_W-1:0]       stall_cnt_o
);
  localparam int ROW_W = ADDR_W - BANK_W;

  logic [1:0]               mode_q;
  logic [ADDR_W-1:0]        base_q, stride_q, addr;
  logic [MAX_VL*ADDR_W-1:0] idx_q;
  logic [ELEM_W-1:0]        elem;
  logic                     fire, store_q;
  logic [CNT_W-1:0]         ret_cnt;
  logic [BANK_W-1:0]        tgt_bank;
  logic [ROW_W-1:0]         tgt_row;
  logic [N_BANKS-1:0]       breq, bbusy, rvld;
  logic [ELEM_W-1:0]        rtag [N_BANKS];
  logic [WORD_W-1:0]        rdat [N_BANKS];
  logic                     m_vld;
  logic [ELEM_W-1:0]        m_tag;
  logic [WORD_W-1:0]        m_dat;

  vbm_issue_ctrl #(
    .ADDR_W(ADDR_W), .N_BANKS(N_BANKS), .BANK_W(BANK_W), .MAX_VL(MAX_VL),
    .ELEM_W(ELEM_W), .CNT_W(CNT_W), .STALL_W(STALL_W)
  ) u_ctrl (
    .clk_i, .rst_ni, .start_i, .store_i, .mode_i, .base_i, .stride_i, .vlen_i, .idx_vec_i,
    .addr_i(addr), .bank_busy_i(bbusy), .wb_valid_i(wb_valid_o),
    .mode_o(mode_q), .base_o(base_q), .stride_o(stride_q), .idx_vec_o(idx_q),
    .elem_o(elem), .fire_o(fire), .store_o(store_q), .done_o(done_o),
    .stall_cnt_o(stall_cnt_o), .ret_cnt_o(ret_cnt)
  );

  vbm_agu #(.ADDR_W(ADDR_W), .MAX_VL(MAX_VL), .ELEM_W(ELEM_W)) u_agu (
    .mode_i(mode_q), .base_i(base_q), .stride_i(stride_q), .idx_vec_i(idx_q),
    .elem_i(elem), .addr_o(addr)
  );

  assign tgt_bank = addr[BANK_W-1:0];
  assign tgt_row  = addr[ADDR_W-1:BANK_W];

  for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
    assign breq[b] = fire && (tgt_bank == BANK_W'(b));
    vbm_bank #(.ROW_W(ROW_W), .WORD_W(WORD_W), .ELEM_W(ELEM_W), .BUSY_CYC(BUSY_CYC)) u_bank (
      .clk_i, .rst_ni, .req_i(breq[b]), .we_i(store_q), .row_i(tgt_row),
      .wdata_i(st_data_i), .tag_i(elem), .busy_o(bbusy[b]),
      .rd_vld_o(rvld[b]), .rd_tag_o(rtag[b]), .rd_data_o(rdat[b])
    );
  end

  // one issue per cycle, so at most one bank returns per cycle
  always_comb begin
    m_vld = 1'b0;
    m_tag = '0;
    m_dat = '0;
    for (int b = 0; b < N_BANKS; b++) begin
      if (rvld[b]) begin
        m_vld = 1'b1;
        m_tag = m_tag | rtag[b];
        m_dat = m_dat | rdat[b];
      end
    end
  end

  vbm_ret_pipe #(.DEPTH(RD_LAT - 1), .ELEM_W(ELEM_W), .WORD_W(WORD_W)) u_ret (
    .clk_i, .rst_ni, .vld_i(m_vld), .tag_i(m_tag), .data_i(m_dat),
    .vld_o(wb_valid_o), .tag_o(wb_elem_o), .data_o(wb_data_o)
  );

  assign bank_req_o = breq;
  assign st_elem_o  = elem;

  a_r5_single_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_req_o));
  a_r5_one_return: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rvld));
  a_r7_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> (CNT_W'(wb_elem_o) == ret_cnt));
  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_store_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> !store_q);
endmodule

// File: tb/vbm_top_test.sv
module vbm_top_test;
  localparam int CLK_PERIOD = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic         store_i = 1'b0;
  logic [1:0]   mode_i = 2'b00;
  logic [7:0]   base_i = '0;
  logic [7:0]   stride_i = '0;
  logic [6:0]   vlen_i = '0;
  logic [511:0] idx_vec_i = '0;
  logic [5:0]   st_elem_o;
  logic [63:0]  st_data_i;
  logic [15:0]  bank_req_o;
  logic         wb_valid_o;
  logic [5:0]   wb_elem_o;
  logic [63:0]  wb_data_o;
  logic         done_o;
  logic [15:0]  stall_cnt_o;

  logic [63:0] st_vals [64];
  logic [63:0] got [64];
  int checks = 0, fails = 0, wd = 0;

  assign st_data_i = st_vals[st_elem_o];

  vbm_top uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference model
  typedef struct { int due; int elem; logic [63:0] data; } ret_t;
  ret_t        q[$];
  int          m_ph = 0, m_vl = 0, m_i = 0, m_ret = 0, m_stall = 0, cyc = 0;
  bit          m_st = 0, m_done = 0;
  logic [1:0]  m_mode = 0;
  logic [7:0]  m_base = 0, m_stride = 0;
  logic [511:0] m_idx = 0;
  int          busy [16];
  logic [63:0] mem [256];

  function automatic logic [7:0] m_addr(input int i);
    logic [7:0] off;
    if (m_mode[1])      off = m_idx[i*8 +: 8];
    else if (m_mode[0]) off = m_stride * 8'(i);
    else                off = 8'(i);
    return m_base + off;
  endfunction

  function automatic logic [15:0] m_req();
    logic [7:0] a;
    if (m_ph != 1) return '0;
    a = m_addr(m_i);
    if (busy[a[3:0]] != 0) return '0;
    return 16'(1) << a[3:0];
  endfunction

  initial for (int b = 0; b < 16; b++) busy[b] = 0;

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      m_ph = 0; m_done = 0; m_stall = 0; q.delete();
      for (int b = 0; b < 16; b++) busy[b] = 0;
    end else begin
      logic [15:0] rq;
      logic [7:0]  a;
      bit          wb_now;
      rq = m_req();
      a = m_addr(m_i);
      for (int b = 0; b < 16; b++) if (busy[b] > 0) busy[b]--;
      if (rq != 0) busy[a[3:0]] = 3;
      wb_now = (q.size() > 0) && (q[0].due == cyc);
      if (wb_now) begin void'(q.pop_front()); m_ret++; end
      m_done = 0;
      if (m_ph == 0) begin
        if (start_i) begin
          m_st = store_i; m_mode = mode_i; m_base = base_i; m_stride = stride_i;
          m_idx = idx_vec_i; m_vl = (vlen_i > 64) ? 64 : int'(vlen_i);
          m_i = 0; m_ret = 0; m_stall = 0;
          if (m_vl == 0) m_done = 1; else m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (rq != 0) begin
          if (m_st) mem[a] = st_vals[m_i];   // R10 scatter/store write
          else q.push_back('{due: cyc + 12, elem: m_i, data: mem[a]});
          m_i++;
          if (m_i == m_vl) begin
            if (m_st) begin m_done = 1; m_ph = 0; end
            else m_ph = 2;
          end
        end else m_stall++;
      end else if (m_ph == 2) begin
        if (wb_now && m_ret == m_vl) begin m_done = 1; m_ph = 0; end
      end
      cyc++;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      bit e_wb;
      chk(bank_req_o == m_req(), "R5", "bank_req", 64'(bank_req_o), 64'(m_req()));
      e_wb = (q.size() > 0) && (q[0].due == cyc);
      chk(wb_valid_o == e_wb, "R7", "wb_valid", 64'(wb_valid_o), 64'(e_wb));
      if (e_wb && wb_valid_o) begin
        chk(wb_elem_o == 6'(q[0].elem), "R7", "wb_elem", 64'(wb_elem_o), 64'(q[0].elem));
        chk(wb_data_o === q[0].data, "R7", "wb_data", wb_data_o, q[0].data);
      end
      chk(done_o == m_done, "R9", "done", 64'(done_o), 64'(m_done));
      chk(stall_cnt_o == 16'(m_stall), "R6", "stall_cnt", 64'(stall_cnt_o), 64'(m_stall));
    end
  end

  always @(posedge clk_i) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL R9 watchdog act=%0d exp=%0d", wd, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_op(input bit st, input logic [1:0] md, input logic [7:0] base,
                        input logic [7:0] stride, input int vlen, input int restart_at,
                        output int cycles, output int nwb);
    @(negedge clk_i);
    store_i = st; mode_i = md; base_i = base; stride_i = stride; vlen_i = 7'(vlen);
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cycles = 1; nwb = 0;
    for (int k = 0; k < 3000; k++) begin
      if (cycles == restart_at) begin
        start_i = 1'b1; vlen_i = 7'd5; base_i = 8'h40; mode_i = 2'b01;
      end else start_i = 1'b0;
      if (wb_valid_o) begin got[wb_elem_o] = wb_data_o; nwb++; end
      if (done_o) break;
      @(negedge clk_i);
      cycles++;
    end
    start_i = 1'b0;
  endtask

  initial begin
    int cyc_n, nwb;
    bit ok;
    repeat (3) @(negedge clk_i);
    chk(bank_req_o == 0 && !done_o && !wb_valid_o, "R6", "reset outputs", 64'(bank_req_o), 0);
    chk(stall_cnt_o == 0, "R6", "reset stall", 64'(stall_cnt_o), 0);
    @(negedge clk_i) rst_ni = 1'b1;

    // fill all 256 words with unit-stride stores
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < 64; i++) st_vals[i] = {8'hC3, 24'(r), 32'(i * 7919 + r * 131)};
      run_op(1, 2'b00, 8'(r * 64), 8'd0, 64, -1, cyc_n, nwb);
      chk(cyc_n == 65, "R10", "store cycles", 64'(cyc_n), 65);
      chk(nwb == 0, "R10", "store writebacks", 64'(nwb), 0);
    end

    // R1 unit load, full length, no conflicts, done timing
    run_op(0, 2'b00, 8'd0, 8'd0, 64, -1, cyc_n, nwb);
    chk(stall_cnt_o == 0, "R1", "unit stalls", 64'(stall_cnt_o), 0);
    chk(cyc_n == 77, "R9", "unit load done cycle", 64'(cyc_n), 77);
    chk(nwb == 64, "R7", "unit writebacks", 64'(nwb), 64);

    // R2 stride equal to bank count
    run_op(0, 2'b01, 8'd3, 8'd16, 8, -1, cyc_n, nwb);
    chk(stall_cnt_o == 21, "R2", "stride16 stalls", 64'(stall_cnt_o), 21);

    // R2 stride 8: two banks alternate
    run_op(0, 2'b01, 8'd1, 8'd8, 10, -1, cyc_n, nwb);
    chk(stall_cnt_o == 8, "R2", "stride8 stalls", 64'(stall_cnt_o), 8);

    // R3 odd stride
    run_op(0, 2'b01, 8'd250, 8'd3, 40, -1, cyc_n, nwb);
    chk(stall_cnt_o == 0, "R3", "stride3 stalls", 64'(stall_cnt_o), 0);
    chk(cyc_n == 53, "R3", "stride3 done cycle", 64'(cyc_n), 53);

    // R4 indexed into one bank
    for (int i = 0; i < 64; i++) idx_vec_i[i*8 +: 8] = 8'(i * 16);
    run_op(0, 2'b10, 8'd5, 8'd0, 6, -1, cyc_n, nwb);
    chk(stall_cnt_o == 15, "R4", "indexed same-bank stalls", 64'(stall_cnt_o), 15);

    // R10 strided scatter, then R4 gather of the same words
    for (int i = 0; i < 64; i++) st_vals[i] = 64'hD0D0_0000_0000_0000 | 64'(i * 3 + 1);
    run_op(1, 2'b01, 8'd7, 8'd5, 20, -1, cyc_n, nwb);
    chk(stall_cnt_o == 0, "R10", "scatter stalls", 64'(stall_cnt_o), 0);
    for (int i = 0; i < 64; i++) idx_vec_i[i*8 +: 8] = 8'(i * 5);
    run_op(0, 2'b11, 8'd7, 8'd0, 20, -1, cyc_n, nwb);
    ok = 1;
    for (int i = 0; i < 20; i++)
      if (got[i] !== (64'hD0D0_0000_0000_0000 | 64'(i * 3 + 1))) ok = 0;
    chk(ok, "R4", "gather returns scattered data", 64'(ok), 1);
    chk(ok, "R10", "stored words readable", 64'(ok), 1);

    // R8 clamp and zero length
    run_op(0, 2'b00, 8'd9, 8'd0, 100, -1, cyc_n, nwb);
    chk(nwb == 64, "R8", "clamped writebacks", 64'(nwb), 64);
    run_op(0, 2'b00, 8'd9, 8'd0, 0, -1, cyc_n, nwb);
    chk(cyc_n == 1 && nwb == 0, "R8", "zero length done", 64'(cyc_n), 1);

    // R11 start mid-operation ignored
    run_op(0, 2'b00, 8'd0, 8'd0, 10, 3, cyc_n, nwb);
    chk(nwb == 10, "R11", "restart ignored count", 64'(nwb), 10);
    chk(cyc_n == 23, "R11", "restart ignored timing", 64'(cyc_n), 23);
    repeat (20) @(negedge clk_i);
    chk(bank_req_o == 0, "R11", "no second operation", 64'(bank_req_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule